// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block hands the external memory bus to an outside master on request. An active-low hold input passes through a short synchronizer. When it is seen low, the arbiter stops issuing new core transactions. It lets any transaction already on the bus run until the external ready input completes it. It then turns off the output enables of the address, data, read/write and strobe drivers, and drives an active-low acknowledge. The pads themselves sit outside the block; only their enable controls appear here.

While the bus is granted away, a core request is remembered rather than lost. It goes out on the first cycle the core owns the bus again. When the hold input returns high, the drivers are enabled one cycle before the acknowledge goes back high, so the bus is never left floating while the core believes it owns it. A control bit, `no_hold`, makes the arbiter ignore hold requests. Setting it while the bus is granted takes the bus back.

Top module: `bus_hold_arbiter`

## Requirements
- R1: While and right after `rst` is high, `holda_n` is 1, every output enable is 1, `core_stall` is 0, `bus_start` is 0 and nothing is in flight.
- R2: With no transaction in flight and `no_hold` at 0, a low on `hold_n_in` that is held makes `holda_n` go low in the cycle after the third rising edge that samples it low.
- R3: If a transaction is in flight (`bus_busy` = 1) when the hold is seen, `holda_n` stays high until the cycle after the edge at which `ext_rdy` is sampled high. That transaction completes first.
- R4: While the bus is released, `addr_oe`, `data_oe`, `rw_oe` and every bit of `strb_oe` are 0, and they are only 0 while `holda_n` is 0.
- R5: While `holda_n` is low, and while waiting for an in-flight transaction to drain, `bus_start` is 0 and `core_stall` is 1.
- R6: When the hold is withdrawn, the output enables return to 1 exactly one cycle before `holda_n` returns to 1.
- R7: While `no_hold` is 1, a hold request has no effect and `holda_n` stays 1. Setting `no_hold` while the bus is released reclaims it through the same enable-then-acknowledge sequence as R6.
- R8: A `core_req` pulse that arrives while the core cannot issue is kept pending. It appears as `bus_start` = 1 in the first cycle the core owns the bus again.
- R9: A hold request withdrawn while a transaction is still draining returns the arbiter to normal ownership without ever driving `holda_n` low.
- R10: `bus_start` follows `core_req` in the same cycle when the core owns the bus, nothing is in flight and no hold is seen. `bus_busy` is 1 from the next cycle until the edge where `ext_rdy` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hold_n_in | input | 1 | Asynchronous active-low hold request from the external master |
| no_hold | input | 1 | Control bit; 1 makes the arbiter ignore hold requests |
| core_req | input | 1 | Single-cycle pulse: the core wants one bus transaction |
| ext_rdy | input | 1 | External ready; completes the transaction in flight |
| bus_start | output | 1 | A transaction is issued onto the bus this cycle |
| bus_busy | output | 1 | A transaction is in flight |
| core_stall | output | 1 | The core does not currently own the bus |
| addr_oe | output | 1 | Address driver enable |
| data_oe | output | 1 | Data driver enable |
| rw_oe | output | 1 | Read/write driver enable |
| strb_oe | output | NUM_STRB | Enables for the memory strobes and the I/O strobe |
| holda_n | output | 1 | Active-low hold acknowledge |

## Verification
The bench drives a hold with the bus idle, which shows the synchronizer latency apart from the drain wait. It then drives a hold that lands on an open transaction with a slow ready, which shows whether the grant waits for completion. A core request placed inside the grant window exposes whether pending requests are kept and when they are issued. Runs with `no_hold` set, both before a hold and during a grant, separate "ignored" from "reclaimed". A hold withdrawn mid-drain shows that the arbiter backs off without ever acknowledging.

// File: rtl/bha_pkg.sv
package bha_pkg;

    typedef enum logic [1:0] {
        ST_OWNED    = 2'd0,
        ST_DRAINING = 2'd1,
        ST_RELEASED = 2'd2,
        ST_REGAIN   = 2'd3
    } bus_state_e;

    typedef struct packed {
        logic drive;   // pad drivers enabled
        logic ack_n;   // active-low acknowledge
    } bus_view_t;

    function automatic bus_view_t view_of(bus_state_e s);
        bus_view_t v;
        v.drive = (s != ST_RELEASED);
        v.ack_n = (s == ST_OWNED) || (s == ST_DRAINING);
        return v;
    endfunction

endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= RESET_VAL;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= {STAGES{RESET_VAL}};
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
    import bha_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hold_eff,
    input  logic       busy,
    input  logic       ext_rdy,
    output bus_state_e state
);
    bus_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OWNED: begin
                if (hold_eff) nxt = (busy && !ext_rdy) ? ST_DRAINING : ST_RELEASED;
            end
            ST_DRAINING: begin
                if (!hold_eff)    nxt = ST_OWNED;
                else if (ext_rdy) nxt = ST_RELEASED;
            end
            ST_RELEASED: begin
                if (!hold_eff) nxt = ST_REGAIN;
            end
            ST_REGAIN: nxt = ST_OWNED;
            default:   nxt = ST_OWNED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_OWNED;
        else     state <= nxt;
    end
endmodule

// File: rtl/bha_txn.sv
module bha_txn (
    input  logic clk,
    input  logic rst,
    input  logic may_issue,
    input  logic core_req,
    input  logic ext_rdy,
    output logic start,
    output logic busy
);
    logic pend;

    assign start = may_issue && !busy && (core_req || pend);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            busy <= 1'b0;
        end else begin
            if (start)         pend <= 1'b0;
            else if (core_req) pend <= 1'b1;

            if (start)                busy <= 1'b1;
            else if (busy && ext_rdy) busy <= 1'b0;
        end
    end
endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter
    import bha_pkg::*;
#(
    parameter int NUM_STRB    = 9,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hold_n_in,
    input  logic                no_hold,
    input  logic                core_req,
    input  logic                ext_rdy,
    output logic                bus_start,
    output logic                bus_busy,
    output logic                core_stall,
    output logic                addr_oe,
    output logic                data_oe,
    output logic                rw_oe,
    output logic [NUM_STRB-1:0] strb_oe,
    output logic                holda_n
);
    logic       hold_sync_n;
    logic       hold_eff;
    bus_state_e state;
    bus_view_t  view;

    bha_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (hold_n_in),
        .q   (hold_sync_n)
    );

    assign hold_eff = !hold_sync_n && !no_hold;

    bha_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .hold_eff (hold_eff),
        .busy     (bus_busy),
        .ext_rdy  (ext_rdy),
        .state    (state)
    );

    bha_txn u_txn (
        .clk       (clk),
        .rst       (rst),
        .may_issue ((state == ST_OWNED) && !hold_eff),
        .core_req  (core_req),
        .ext_rdy   (ext_rdy),
        .start     (bus_start),
        .busy      (bus_busy)
    );

    assign view       = view_of(state);
    assign core_stall = (state != ST_OWNED);
    assign addr_oe    = view.drive;
    assign data_oe    = view.drive;
    assign rw_oe      = view.drive;
    assign holda_n    = view.ack_n;

    generate
        for (genvar i = 0; i < NUM_STRB; i++) begin : g_strb
            assign strb_oe[i] = view.drive;
        end
    endgenerate
endmodule

// File: rtl/bha_chk.sv
module bha_chk #(
    parameter int NUM_STRB = 9
) (
    input logic                clk,
    input logic                rst,
    input logic                no_hold,
    input logic                bus_start,
    input logic                bus_busy,
    input logic                addr_oe,
    input logic [NUM_STRB-1:0] strb_oe,
    input logic                holda_n
);
    // R3
    drain_before_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(holda_n) |-> !bus_busy);

    // R5
    no_issue_when_granted_chk: assert property (@(posedge clk) disable iff (rst)
        !holda_n |-> !bus_start);

    // R4
    float_only_when_granted_chk: assert property (@(posedge clk) disable iff (rst)
        (!addr_oe || strb_oe != '1) |-> !holda_n);

    // R6
    enable_before_ack_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(holda_n) |-> $past(addr_oe));

    // R6
    reenable_while_acked_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(addr_oe) |-> !holda_n);

    // R7
    no_hold_blocks_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (no_hold && holda_n) |=> holda_n);
endmodule

bind bus_hold_arbiter bha_chk #(.NUM_STRB(NUM_STRB)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .no_hold   (no_hold),
    .bus_start (bus_start),
    .bus_busy  (bus_busy),
    .addr_oe   (addr_oe),
    .strb_oe   (strb_oe),
    .holda_n   (holda_n)
);

// File: tb/bus_hold_arbiter_tb_top.sv
module bus_hold_arbiter_tb_top;
    localparam int NS = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hold_n_in = 1'b1;
    logic no_hold = 1'b0;
    logic core_req = 1'b0;
    logic ext_rdy = 1'b0;
    logic bus_start, bus_busy, core_stall, addr_oe, data_oe, rw_oe, holda_n;
    logic [NS-1:0] strb_oe;

    always #4 clk = ~clk;   // 125 MHz

    bus_hold_arbiter #(.NUM_STRB(NS)) dut_i (
        .clk(clk), .rst(rst), .hold_n_in(hold_n_in), .no_hold(no_hold),
        .core_req(core_req), .ext_rdy(ext_rdy), .bus_start(bus_start),
        .bus_busy(bus_busy), .core_stall(core_stall), .addr_oe(addr_oe),
        .data_oe(data_oe), .rw_oe(rw_oe), .strb_oe(strb_oe), .holda_n(holda_n)
    );

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // behavioural reference: sampled hold history plus a mode number
    // mode 0 = core owns, 1 = waiting on ready, 2 = granted, 3 = taking back
    bit h_q [$];
    int mode = 0;
    bit m_busy = 0;
    bit m_pend = 0;

    task automatic chk(string req, string what, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic bit seen_hold();
        return (h_q[1] == 1'b0) && !no_hold;
    endfunction

    function automatic bit exp_start();
        return (mode == 0) && !seen_hold() && !m_busy && (core_req || m_pend);
    endfunction

    task automatic compare_all();
        bit drv;
        drv = (mode != 2);
        chk(cur_req, "holda_n", holda_n, (mode == 0 || mode == 1));
        chk(cur_req, "addr_oe", addr_oe, drv);
        chk(cur_req, "data_oe", data_oe, drv);
        chk(cur_req, "rw_oe", rw_oe, drv);
        chk(cur_req, "strb_oe", (strb_oe == {NS{drv}}), 1'b1);
        chk(cur_req, "core_stall", core_stall, (mode != 0));
        chk(cur_req, "bus_start", bus_start, exp_start());
        chk(cur_req, "bus_busy", bus_busy, m_busy);
    endtask

    task automatic advance_model();
        bit st, eff;
        int nm;
        if (rst) begin
            h_q = '{1'b1, 1'b1};
            mode = 0; m_busy = 0; m_pend = 0;
            return;
        end
        st = exp_start();
        eff = seen_hold();
        nm = mode;
        case (mode)
            0: if (eff) nm = (m_busy && !ext_rdy) ? 1 : 2;
            1: if (!eff) nm = 0; else if (ext_rdy) nm = 2;
            2: if (!eff) nm = 3;
            default: nm = 0;
        endcase
        if (st) m_pend = 0; else if (core_req) m_pend = 1;
        if (st) m_busy = 1; else if (m_busy && ext_rdy) m_busy = 0;
        mode = nm;
        h_q = '{hold_n_in, h_q[0]};
    endtask

    task automatic cyc();
        #1;
        compare_all();
        advance_model();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        h_q = '{1'b1, 1'b1};
        @(posedge clk);
        @(negedge clk);
        // R1 reset state
        cur_req = "R1";
        run(3);
        rst = 1'b0;
        chk("R1", "holda_n after reset", holda_n, 1'b1);
        run(2);

        // R10 plain transaction
        cur_req = "R10";
        core_req = 1'b1;
        #1 chk("R10", "same-cycle start", bus_start, 1'b1);
        cyc();
        core_req = 1'b0;
        chk("R10", "busy after start", bus_busy, 1'b1);
        run(2);
        ext_rdy = 1'b1; cyc(); ext_rdy = 1'b0;
        chk("R10", "busy cleared", bus_busy, 1'b0);
        run(2);

        // R2 idle hold, latency of the synchronizer
        cur_req = "R2";
        hold_n_in = 1'b0;
        run(2);
        chk("R2", "holda_n before sync done", holda_n, 1'b1);
        cyc();
        chk("R2", "holda_n granted", holda_n, 1'b0);
        chk("R4", "addr_oe off", addr_oe, 1'b0);
        chk("R4", "strb_oe off", (strb_oe == '0), 1'b1);
        cur_req = "R4";
        run(3);

        // R6 release
        cur_req = "R6";
        hold_n_in = 1'b1;
        run(3);
        chk("R6", "enables back", addr_oe, 1'b1);
        chk("R6", "ack still low", holda_n, 1'b0);
        cyc();
        chk("R6", "ack high", holda_n, 1'b1);
        run(2);

        // R3 hold meets an open transaction
        cur_req = "R3";
        core_req = 1'b1; cyc(); core_req = 1'b0;
        hold_n_in = 1'b0;
        run(6);
        chk("R3", "ack waits for ready", holda_n, 1'b1);
        chk("R5", "stalled while draining", core_stall, 1'b1);
        ext_rdy = 1'b1; cyc(); ext_rdy = 1'b0;
        chk("R3", "ack after ready", holda_n, 1'b0);

        // R5 / R8 request while granted
        cur_req = "R8";
        core_req = 1'b1;
        #1 chk("R5", "no start while granted", bus_start, 1'b0);
        cyc();
        core_req = 1'b0;
        run(2);
        hold_n_in = 1'b1;
        run(4);
        #1 chk("R8", "pending issued on regain", bus_start, 1'b1);
        cyc();
        ext_rdy = 1'b1; cyc(); ext_rdy = 1'b0;
        run(2);

        // R7 no_hold ignores request
        cur_req = "R7";
        no_hold = 1'b1;
        hold_n_in = 1'b0;
        run(6);
        chk("R7", "ack stays high", holda_n, 1'b1);
        core_req = 1'b1;
        #1 chk("R7", "core still issues", bus_start, 1'b1);
        cyc();
        core_req = 1'b0;
        ext_rdy = 1'b1; cyc(); ext_rdy = 1'b0;
        no_hold = 1'b0;
        run(2);
        chk("R7", "granted once bit cleared", holda_n, 1'b0);
        no_hold = 1'b1;
        cyc();
        chk("R7", "enables back on reclaim", addr_oe, 1'b1);
        chk("R7", "ack low for one more cycle", holda_n, 1'b0);
        cyc();
        chk("R7", "reclaimed", holda_n, 1'b1);
        run(2);
        hold_n_in = 1'b1;
        no_hold = 1'b0;
        run(3);

        // R9 hold withdrawn mid-drain
        cur_req = "R9";
        core_req = 1'b1; cyc(); core_req = 1'b0;
        hold_n_in = 1'b0;
        run(4);
        hold_n_in = 1'b1;
        run(4);
        chk("R9", "never acknowledged", holda_n, 1'b1);
        chk("R9", "owned again", core_stall, 1'b0);
        ext_rdy = 1'b1; cyc(); ext_rdy = 1'b0;
        run(3);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule